// File: doc/BRIEF.md
# Shadow-Updated Pulse-Width Modulator Channel

This block produces one pulse-width modulated output from three settings held in shadow registers: a clock prescale, a period length and an active (duty) length. Writes through a small address/data port change only the shadow copies. The live generator keeps running on its current settings until a qualified trigger event moves the shadow values across. A qualified event is a trigger bit that has been low for a minimum time, then goes high and stays high for that same minimum time. The minimum time is a cycle count derived from a 400 ns gap and the clock period.

A smooth-hold bit in the control word stops a trigger event from moving the settings across, so the old waveform keeps running while software reprograms the shadows. An output-invert bit is stored at once but only reaches the pin through a transfer. Moved settings wait in a pending stage and are adopted at the end of the running period. If the generator is idle, they are adopted at once. Programming zero for prescale, period and duty and transferring them parks the output at its inactive level, which serves as the disable.

Top module: `pwm_shadow_chan`

## Requirements
- R1: Writes to prescale (address 1), period (address 2) or duty (address 3) leave the output waveform unchanged until a qualified trigger event occurs.
- R2: When the smooth-hold bit (control bit 1) is 1 at the moment a trigger event qualifies, no transfer happens and the old waveform continues.
- R3: A trigger bit (control bit 0, address 0) that has been low for at least MIN_CYC cycles, then goes high and stays high for MIN_CYC cycles with smooth-hold at 0, transfers the shadow prescale, period, duty and invert values to the generator.
- R4: A trigger high pulse shorter than MIN_CYC cycles causes no transfer.
- R5: A rising trigger edge that follows a low time shorter than MIN_CYC cycles causes no transfer, even if the trigger then stays high.
- R6: While the applied period is 0, the output sits at its inactive level: 0, or 1 when the applied invert bit is 1.
- R7: The invert bit (control bit 2) has no effect on the output until a transfer. After a transfer with it set, the output is the complement of the non-inverted waveform.
- R8: One period lasts period × (prescale + 1) clock cycles.
- R9: The output is active for min(duty, period) × (prescale + 1) cycles of each period, starting at the period start. A duty of period or more keeps it active for the whole period.
- R10: Transferred settings are adopted only at a period boundary, or at once when the generator is idle, so no pulse of a length belonging to neither setting appears.
- R11: Synchronous reset clears all counters and settings and drives the output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 prescale, 2 period, 3 duty |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 1 | Modulated output |

## Verification
On every cycle, the assertions check that applied settings stay frozen unless a transfer is pending. They also check that adoption lands only on a period boundary, that smooth-hold blocks the pending stage from arming, that a pending transfer appears only after MIN_CYC high cycles, and that an idle generator holds the inactive level. Only the bench's scenarios show the waveform itself. These are the high-cycle counts over whole periods for each prescale, period and duty mix, the rejection of short high and short low pulses, the delayed effect of the invert bit, and clean pulse lengths across an update.

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan #(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int CLK_PS = 4000,
  parameter int GAP_NS = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out
);
  localparam int MIN_CYC = (GAP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RUN_W   = $clog2(MIN_CYC + 1);
  localparam logic [1:0] A_CTL = 2'd0, A_PRE = 2'd1, A_PER = 2'd2, A_DUTY = 2'd3;

  logic             ctl_trig, ctl_smooth, ctl_pol;
  logic [PRE_W-1:0] sh_pre, pend_pre, act_pre, pre_cnt;
  logic [CNT_W-1:0] sh_per, sh_duty, pend_per, pend_duty, act_per, act_duty, per_cnt;
  logic             pend, pend_pol, act_pol;
  logic             trig_prev, armed;
  logic [RUN_W-1:0] run_cnt;
  logic             fire, idle, tick, period_end, load;

  always_ff @(posedge clk) begin
    if (rst) begin
      {ctl_pol, ctl_smooth, ctl_trig} <= '0;
      sh_pre  <= '0;
      sh_per  <= '0;
      sh_duty <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTL:  {ctl_pol, ctl_smooth, ctl_trig} <= wr_data[2:0];
        A_PRE:  sh_pre  <= wr_data[PRE_W-1:0];
        A_PER:  sh_per  <= wr_data;
        A_DUTY: sh_duty <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_prev <= 1'b0;
      run_cnt   <= '0;
      armed     <= 1'b0;
    end else begin
      trig_prev <= ctl_trig;
      if (ctl_trig != trig_prev)
        run_cnt <= RUN_W'(1);
      else if (run_cnt != RUN_W'(MIN_CYC))
        run_cnt <= run_cnt + RUN_W'(1);
      if (ctl_trig && !trig_prev)
        armed <= (run_cnt == RUN_W'(MIN_CYC));
      else if (!ctl_trig)
        armed <= 1'b0;
    end
  end

  assign fire       = ctl_trig && trig_prev && armed && (run_cnt == RUN_W'(MIN_CYC - 1));
  assign idle       = (act_per == '0);
  assign tick       = (pre_cnt == act_pre);
  assign period_end = tick && ((per_cnt + CNT_W'(1)) == act_per);
  assign load       = pend && (idle || period_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_pre  <= '0;
      pend_per  <= '0;
      pend_duty <= '0;
      pend_pol  <= 1'b0;
      act_pre   <= '0;
      act_per   <= '0;
      act_duty  <= '0;
      act_pol   <= 1'b0;
      pre_cnt   <= '0;
      per_cnt   <= '0;
    end else begin
      if (load) begin
        act_pre  <= pend_pre;
        act_per  <= pend_per;
        act_duty <= pend_duty;
        act_pol  <= pend_pol;
        pre_cnt  <= '0;
        per_cnt  <= '0;
        pend     <= 1'b0;
      end else if (idle) begin
        pre_cnt <= '0;
        per_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= '0;
        per_cnt <= period_end ? '0 : per_cnt + CNT_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
      if (fire && !ctl_smooth) begin
        pend      <= 1'b1;
        pend_pre  <= sh_pre;
        pend_per  <= sh_per;
        pend_duty <= sh_duty;
        pend_pol  <= ctl_pol;
      end
    end
  end

  assign pwm_out = (!idle && (per_cnt < act_duty)) ^ act_pol;
endmodule

// File: rtl/pwm_shadow_chan_chk.sv
module pwm_shadow_chan_chk #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int MIN_CYC = 100
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input logic             ctl_trig,
  input logic             ctl_smooth,
  input logic             pend,
  input logic [PRE_W-1:0] act_pre,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] act_duty,
  input logic             act_pol,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [CNT_W-1:0] per_cnt
);
  localparam int HW = $clog2(MIN_CYC + 1);
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst || !ctl_trig) hi_run <= '0;
    else if (hi_run != HW'(MIN_CYC)) hi_run <= hi_run + HW'(1);
  end

  a_r11_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pwm_out && !pend && per_cnt == '0 && act_per == '0));

  a_r1_frozen_without_pend: assert property (@(posedge clk) disable iff (rst)
    (!pend && act_per != '0) |=> ($stable(act_per) && $stable(act_duty) && $stable(act_pre) && $stable(act_pol)));

  a_r2_smooth_holds: assert property (@(posedge clk) disable iff (rst)
    (ctl_smooth && !pend) |=> !pend);

  a_r4_high_time: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> (hi_run >= HW'(MIN_CYC)));

  a_r6_idle_inactive: assert property (@(posedge clk) disable iff (rst)
    (act_per == '0) |-> (pwm_out == act_pol));

  a_r10_boundary_only: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_per) || !$stable(act_duty) || !$stable(act_pre)) |-> (per_cnt == '0 && pre_cnt == '0));
endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .MIN_CYC(MIN_CYC)) u_chk (.*);

// File: tb/pwm_shadow_chan_test.sv
`timescale 1ns/1ps
module pwm_shadow_chan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;

  int errors = 0;
  int checks = 0;
  int push_cnt = 0;
  int done_cnt = 0;

  typedef struct {
    int    kind;
    int    len;
    int    a;
    int    b;
    string tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  pwm_shadow_chan uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input int pol, input int smooth, input int trig);
    wr(2'd0, pol * 4 + smooth * 2 + trig);
  endtask

  task automatic cfg(input int pre, input int per, input int duty);
    wr(2'd1, pre); wr(2'd2, per); wr(2'd3, duty);
  endtask

  task automatic apply(input int pol);
    ctl(pol, 0, 0); idle(120);
    ctl(pol, 0, 1); idle(160);
  endtask

  task automatic push(input int kind, input int len, input int a, input int b, input string tag);
    item_t it;
    it.kind = kind; it.len = len; it.a = a; it.b = b; it.tag = tag;
    q.push_back(it);
    push_cnt++;
    wait (done_cnt == push_cnt);
  endtask

  initial begin
    forever begin
      item_t it;
      int ones, run, bad, lastbad, seen_b;
      bit started;
      wait (q.size() > 0);
      it = q.pop_front();
      ones = 0; run = 0; bad = 0; lastbad = 0; seen_b = 0; started = 1'b0;
      for (int i = 0; i < it.len; i++) begin
        @(negedge clk);
        if (pwm_out) begin
          ones++;
          if (started) run++;
        end else begin
          if (started && run > 0) begin
            if (run == it.b) seen_b++;
            else if (run != it.a) begin bad++; lastbad = run; end
          end
          run = 0;
          started = 1'b1;
        end
      end
      checks++;
      if (it.kind == 0) begin
        if (ones != it.a) begin
          errors++;
          $display("FAIL %s: high cycles actual=%0d expected=%0d", it.tag, ones, it.a);
        end
      end else if (bad != 0 || seen_b == 0) begin
        errors++;
        $display("FAIL %s: pulse length actual=%0d (new seen %0d) expected=%0d or %0d",
                 it.tag, lastbad, seen_b, it.a, it.b);
      end
      done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (pwm_out !== 1'b0) begin
      errors++;
      $display("FAIL R11: pwm_out after reset actual=%b expected=0", pwm_out);
    end
    push(0, 50, 0, 0, "R11");

    cfg(0, 10, 3); apply(0);
    push(0, 100, 30, 0, "R3");

    cfg(0, 20, 15);
    push(0, 100, 30, 0, "R1");

    ctl(0, 0, 0); idle(10); ctl(0, 0, 1); idle(200);
    push(0, 100, 30, 0, "R5");

    ctl(0, 0, 0); idle(120); ctl(0, 0, 1); idle(20); ctl(0, 0, 0); idle(150);
    push(0, 100, 30, 0, "R4");

    ctl(0, 0, 0); idle(120); ctl(0, 0, 1); idle(80);
    push(1, 80, 3, 15, "R10");
    idle(20);
    push(0, 200, 150, 0, "R3");

    ctl(0, 1, 0); cfg(0, 8, 2); idle(120); ctl(0, 1, 1); idle(160);
    push(0, 200, 150, 0, "R2");

    cfg(3, 5, 2); apply(0);
    push(0, 200, 80, 0, "R8");

    cfg(0, 6, 9); apply(0);
    push(0, 60, 60, 0, "R9");

    ctl(1, 0, 1); idle(30);
    push(0, 60, 60, 0, "R7");
    apply(1);
    push(0, 60, 0, 0, "R7");
    cfg(0, 10, 3); apply(1);
    push(0, 100, 70, 0, "R7");

    cfg(0, 0, 0); apply(0);
    push(0, 100, 0, 0, "R6");
    apply(1);
    push(0, 100, 100, 0, "R6");

    cfg(0, 10, 5); apply(0);
    push(0, 100, 50, 0, "R3");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule